// File: doc/BRIEF.md
# SMBus Indexed Block Register Slave

This block is a target on a two-wire SMBus/I2C bus. It gives a host access to a small bank of 8-bit configuration registers through indexed block transfers. SCL and SDA reach it already synchronized to the system clock and filtered. It pulls SDA low through an open-drain enable and never drives it high. The register storage sits outside the block. The block issues one-cycle write strobes with an index and a data byte, and it presents a read index whose data comes back combinationally.

A host write carries the target address, a starting index, a byte count and then that many data bytes. These bytes land in consecutive registers, and the index wraps at the end of the bank. A host read first sets the index with a short write phase and then issues a repeated start with the read address. The target answers with a count byte taken from a dedicated count register and then streams registers from the index onward until the host declines a byte. A start or stop anywhere aborts the transfer in progress. Registers outside the writable mask accept bytes on the bus, but the block never writes them.

Top module: `smbus_idx_regs`

## Requirements
- R1: The target acknowledges the address byte 0xD2 (7-bit address 0x69, write) and 0xD3 (read). Any other address byte gets no acknowledge, and SDA is not pulled again before the next start condition.
- R2: In a write transfer, the byte after the address sets the starting index N from its low log2(NUM_REGS) bits. The next byte is the count X. Each of the following X data bytes is acknowledged and written to index N, N+1, … through a single-cycle `wr_en` pulse that carries `wr_idx` and `wr_data`.
- R3: Data bytes beyond the count X of a write transfer are not acknowledged and produce no write strobe.
- R4: After a repeated start with 0xD3, the target first sends the count register value, which is 0x00 after reset. It then sends the registers starting at the index set in the write phase, most significant bit first.
- R5: While the host acknowledges, the target sends the next register. After a host not-acknowledge, the target leaves SDA released until the next start condition.
- R6: The index advances by one after each written or sent data byte and wraps from NUM_REGS-1 (15) to 0.
- R7: A byte written to index 8 becomes the count that later reads return first.
- R8: A data byte aimed at an index whose WR_MASK bit is 0 (indices 9 to 15 by default) is still acknowledged. It produces no write strobe, and the index still advances.
- R9: A start or stop condition in the middle of a transfer aborts it. Bytes acknowledged before the abort stay written, a partly received byte is dropped, and after a start the next byte is matched as an address again.
- R10: The open-drain enable `sda_oe` (1 = pull SDA low) changes only while SCL is low. A start or stop condition leaves it at 0 on the following cycle.
- R11: After reset, `sda_oe` and `wr_en` are 0 and `rd_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized, filtered SCL level |
| sda_i | input | 1 | Synchronized, filtered SDA level (wired bus value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_idx | output | IW | Register index of the write |
| wr_data | output | 8 | Register data of the write |
| rd_idx | output | IW | Index of the register to present on rd_data |
| rd_data | input | 8 | Register contents at rd_idx (combinational) |

## Verification
Bus levels pass through one register stage for edge detection. Every SDA drive change therefore appears on `sda_oe` one clock after the first clock in which SCL is seen low, and a write strobe appears one clock after the falling SCL edge that ends the eighth data bit. The bench moves inputs on the falling clock edge and holds each bus phase for five clocks. It reads acknowledge and data bits in the middle of the SCL-high phase, well after the two clocks the design needs to settle SDA. Register effects are compared only after a whole transfer, using write-strobe counts and the bench's own storage. A clocked monitor counts every change of `sda_oe` seen while SCL is high.

// File: rtl/smbus_idx_pkg.sv
package smbus_idx_pkg;

   // Bus-engine phases of the target
   typedef enum logic [2:0] {
      ST_IDLE,   // not addressed, wait for a start
      ST_RX,     // shifting in a byte from the host
      ST_ACK,    // holding the acknowledge bit low
      ST_TX,     // shifting out a byte to the host
      ST_MACK    // sampling the host acknowledge
   } bus_state_t;

   // Meaning of the byte currently being received
   typedef enum logic [1:0] {
      RX_ADDR,
      RX_INDEX,
      RX_COUNT,
      RX_DATA
   } rx_kind_t;

endpackage

// File: rtl/smbus_idx_cond.sv
// Edge and bus-condition detector for pre-synchronized SCL/SDA
module smbus_idx_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise  =  scl_i && !scl_q;
   assign scl_fall  = !scl_i &&  scl_q;
   assign start_det =  scl_i &&  scl_q &&  sda_q && !sda_i;
   assign stop_det  =  scl_i &&  scl_q && !sda_q &&  sda_i;

endmodule

// File: rtl/smbus_idx_index.sv
// Register index pointer: load from the index byte, step with wrap
module smbus_idx_index #(
   parameter int NUM_REGS = 16,
   localparam int IW = (NUM_REGS > 2) ? $clog2(NUM_REGS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [7:0]    load_val,
   input  logic          step,
   output logic [IW-1:0] idx
);

   localparam logic [IW-1:0] LAST    = IW'(NUM_REGS - 1);
   localparam logic [8:0]    LIMIT   = 9'(NUM_REGS);
   localparam bit            IS_POW2 = ((NUM_REGS & (NUM_REGS - 1)) == 0);

   logic [IW-1:0] load_idx;
   logic [IW-1:0] next_idx;
   logic          unused_load_bits;

   assign unused_load_bits = ^load_val;

   generate
      if (IS_POW2) begin : g_pow2
         // natural wrap of the counter width
         assign load_idx = load_val[IW-1:0];
         assign next_idx = idx + 1'b1;
      end else begin : g_mod
         // out-of-range start falls back to index 0
         assign load_idx = ({1'b0, load_val} < LIMIT) ? load_val[IW-1:0] : '0;
         assign next_idx = (idx == LAST) ? '0 : idx + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx <= '0;
      else if (load)
         idx <= load_idx;
      else if (step)
         idx <= next_idx;
   end

endmodule

// File: rtl/smbus_idx_count.sv
// Shadow of the count register returned first on every read
module smbus_idx_count #(
   parameter logic [7:0] COUNT_RESET = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] din,
   output logic [7:0] count
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= COUNT_RESET;
      else if (we)
         count <= din;
   end

endmodule

// File: rtl/smbus_idx_regs.sv
// SMBus target with indexed block write and block read
module smbus_idx_regs
   import smbus_idx_pkg::*;
#(
   parameter logic [6:0]          ADDR7       = 7'h69,
   parameter int                  NUM_REGS    = 16,
   parameter int                  COUNT_IDX   = 8,
   parameter logic [7:0]          COUNT_RESET = 8'h00,
   parameter logic [NUM_REGS-1:0] WR_MASK     = NUM_REGS'(9'h1FF),
   localparam int                 IW          = (NUM_REGS > 2) ? $clog2(NUM_REGS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          sda_oe,
   output logic          wr_en,
   output logic [IW-1:0] wr_idx,
   output logic [7:0]    wr_data,
   output logic [IW-1:0] rd_idx,
   input  logic [7:0]    rd_data
);

   localparam logic [IW-1:0] CNT_IDX = IW'(COUNT_IDX);

   // elaboration-time parameter checks
   generate
      if (NUM_REGS < 2 || NUM_REGS > 256) begin : g_bad_num_regs
         $error("NUM_REGS must lie in 2..256");
      end
      if (COUNT_IDX < 0 || COUNT_IDX >= NUM_REGS) begin : g_bad_count_idx
         $error("COUNT_IDX must address an implemented register");
      end
   endgenerate

   logic scl_rise, scl_fall, start_det, stop_det;

   smbus_idx_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   bus_state_t    state;
   rx_kind_t      kind;
   rx_kind_t      ack_kind;
   logic          ack_to_tx;
   logic [7:0]    shreg;
   logic [3:0]    bitcnt;
   logic [7:0]    remaining;
   logic          host_ack;
   logic          oe_q;
   logic          wr_en_q;
   logic [IW-1:0] wr_idx_q;
   logic [7:0]    wr_data_q;
   logic [IW-1:0] idx;
   logic [7:0]    count_q;

   // byte-level events
   logic byte_done, addr_hit, data_take, idx_load, idx_step, tx_next, cnt_we, idx_writable;

   assign byte_done    = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
   assign addr_hit     = (shreg[7:1] == ADDR7);
   assign data_take    = byte_done && (kind == RX_DATA) && (remaining != 8'd0);
   assign idx_load     = byte_done && (kind == RX_INDEX);
   assign tx_next      = (state == ST_MACK) && scl_fall && host_ack;
   assign idx_step     = data_take || tx_next;
   assign idx_writable = WR_MASK[idx];
   assign cnt_we       = data_take && idx_writable && (idx == CNT_IDX);

   smbus_idx_index #(.NUM_REGS(NUM_REGS)) u_index (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (idx_load),
      .load_val (shreg),
      .step     (idx_step),
      .idx      (idx)
   );

   smbus_idx_count #(.COUNT_RESET(COUNT_RESET)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cnt_we),
      .din   (shreg),
      .count (count_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         kind      <= RX_ADDR;
         ack_kind  <= RX_ADDR;
         ack_to_tx <= 1'b0;
         shreg     <= '0;
         bitcnt    <= '0;
         remaining <= '0;
         host_ack  <= 1'b0;
         oe_q      <= 1'b0;
         wr_en_q   <= 1'b0;
         wr_idx_q  <= '0;
         wr_data_q <= '0;
      end else begin
         wr_en_q <= 1'b0;
         if (start_det) begin
            state  <= ST_RX;
            kind   <= RX_ADDR;
            bitcnt <= '0;
            oe_q   <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            oe_q   <= 1'b0;
         end else begin
            case (state)
               ST_RX: begin
                  if (scl_rise && bitcnt != 4'd8) begin
                     shreg  <= {shreg[6:0], sda_i};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (byte_done) begin
                     bitcnt <= '0;
                     case (kind)
                        RX_ADDR: begin
                           if (addr_hit) begin
                              state     <= ST_ACK;
                              oe_q      <= 1'b1;
                              ack_to_tx <= shreg[0];
                              ack_kind  <= RX_INDEX;
                           end else begin
                              state <= ST_IDLE;
                           end
                        end
                        RX_INDEX: begin
                           state     <= ST_ACK;
                           oe_q      <= 1'b1;
                           ack_to_tx <= 1'b0;
                           ack_kind  <= RX_COUNT;
                        end
                        RX_COUNT: begin
                           state     <= ST_ACK;
                           oe_q      <= 1'b1;
                           ack_to_tx <= 1'b0;
                           ack_kind  <= RX_DATA;
                           remaining <= shreg;
                        end
                        default: begin
                           if (data_take) begin
                              state     <= ST_ACK;
                              oe_q      <= 1'b1;
                              ack_to_tx <= 1'b0;
                              ack_kind  <= RX_DATA;
                              remaining <= remaining - 8'd1;
                              wr_en_q   <= idx_writable;
                              wr_idx_q  <= idx;
                              wr_data_q <= shreg;
                           end else begin
                              state <= ST_IDLE;
                           end
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     if (ack_to_tx) begin
                        state  <= ST_TX;
                        shreg  <= count_q;
                        oe_q   <= ~count_q[7];
                        bitcnt <= '0;
                     end else begin
                        state <= ST_RX;
                        kind  <= ack_kind;
                        oe_q  <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bitcnt == 4'd7) begin
                        state    <= ST_MACK;
                        oe_q     <= 1'b0;
                        bitcnt   <= '0;
                        host_ack <= 1'b0;
                     end else begin
                        shreg  <= {shreg[6:0], 1'b0};
                        oe_q   <= ~shreg[6];
                        bitcnt <= bitcnt + 4'd1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     host_ack <= ~sda_i;
                  end else if (scl_fall) begin
                     if (host_ack) begin
                        state <= ST_TX;
                        shreg <= rd_data;
                        oe_q  <= ~rd_data[7];
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe  = oe_q;
   assign wr_en   = wr_en_q;
   assign wr_idx  = wr_idx_q;
   assign wr_data = wr_data_q;
   assign rd_idx  = idx;

endmodule

// File: rtl/smbus_idx_regs_chk.sv
// Protocol checker attached to the target
module smbus_idx_regs_chk #(
   parameter int                  NUM_REGS = 16,
   parameter logic [NUM_REGS-1:0] WR_MASK  = NUM_REGS'(9'h1FF),
   localparam int                 IW       = (NUM_REGS > 2) ? $clog2(NUM_REGS) : 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_i,
   input logic          sda_i,
   input logic          sda_oe,
   input logic          wr_en,
   input logic [IW-1:0] wr_idx
);

   // R10: drive changes happen only with SCL low
   assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);

   // R5 / R10: a stop condition leaves SDA released
   assert_stop_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> !sda_oe);

   // R9: a start condition aborts and releases SDA
   assert_start_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_i && $past(scl_i) && $past(sda_i) && !sda_i) |=> !sda_oe);

   // R2: a write strobe lasts exactly one cycle
   assert_wr_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R2: a write strobe follows a completed byte, with SCL low
   assert_wr_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_en) |-> (!scl_i && !$past(scl_i)));

   // R8: never a strobe to a protected index
   assert_wr_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> WR_MASK[wr_idx]);

endmodule

bind smbus_idx_regs smbus_idx_regs_chk #(
   .NUM_REGS (NUM_REGS),
   .WR_MASK  (WR_MASK)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .scl_i  (scl_i),
   .sda_i  (sda_i),
   .sda_oe (sda_oe),
   .wr_en  (wr_en),
   .wr_idx (wr_idx)
);

// File: tb/smbus_idx_regs_tb.sv
module smbus_idx_regs_tb;

   localparam int NREG = 16;
   localparam int IW   = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          scl;
   logic          sda_h;
   logic          sda_oe;
   logic          wr_en;
   logic [IW-1:0] wr_idx;
   logic [7:0]    wr_data;
   logic [IW-1:0] rd_idx;
   logic [7:0]    rd_data;
   wire           sda_line = sda_h & ~sda_oe;

   always #5 clk = ~clk;

   smbus_idx_regs u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (scl),
      .sda_i   (sda_line),
      .sda_oe  (sda_oe),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   // external register storage, initial value 0xA0 + index
   logic [7:0] bank [NREG];
   int         wr_cnt;
   int         oe_bad;
   logic       oe_prev;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) bank[i] <= 8'hA0 + 8'(i);
         wr_cnt  <= 0;
         oe_bad  <= 0;
         oe_prev <= 1'b0;
      end else begin
         if (wr_en) begin
            bank[wr_idx] <= wr_data;
            wr_cnt       <= wr_cnt + 1;
         end
         if (sda_oe !== oe_prev && scl) oe_bad <= oe_bad + 1;
         oe_prev <= sda_oe;
      end
   end

   assign rd_data = bank[rd_idx];

   int   tests = 0;
   int   fails = 0;
   bit   done  = 1'b0;
   logic [7:0] wbuf [8];
   logic [7:0] rbuf [8];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic q;
      repeat (5) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_h = 1'b1; q; scl = 1'b1; q; sda_h = 1'b0; q; scl = 1'b0;
   endtask

   task automatic bus_stop;
      sda_h = 1'b0; q; scl = 1'b1; q; sda_h = 1'b1; q;
   endtask

   task automatic send_bit(input bit b);
      sda_h = b; q; scl = 1'b1; q; q; scl = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_h = 1'b1; q; scl = 1'b1; q; ack = !sda_line; q; scl = 1'b0;
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sda_h = 1'b1; q; scl = 1'b1; q; b[i] = sda_line; q; scl = 1'b0;
      end
      sda_h = !give_ack; q; scl = 1'b1; q; q; scl = 1'b0;
   endtask

   task automatic blk_write(input logic [7:0] n, input logic [7:0] x, input int nb,
                            output bit hdr_ok, output int dacks);
      bit a;
      bus_start;
      send_byte(8'hD2, a); hdr_ok = a;
      send_byte(n, a);     hdr_ok &= a;
      send_byte(x, a);     hdr_ok &= a;
      dacks = 0;
      for (int i = 0; i < nb; i++) begin
         send_byte(wbuf[i], a);
         if (a) dacks++;
      end
      bus_stop;
   endtask

   task automatic blk_read(input logic [7:0] n, input int nd,
                           output bit hdr_ok, output logic [7:0] cnt);
      bit a;
      logic [7:0] b;
      bus_start;
      send_byte(8'hD2, a); hdr_ok = a;
      send_byte(n, a);     hdr_ok &= a;
      bus_start;
      send_byte(8'hD3, a); hdr_ok &= a;
      recv_byte(nd != 0, cnt);
      for (int i = 0; i < nd; i++) begin
         recv_byte(i != nd - 1, b);
         rbuf[i] = b;
      end
      bus_stop;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      chk(sda_oe == 1'b0, "R11", "sda_oe after reset", int'(sda_oe), 0);
      chk(wr_en == 1'b0,  "R11", "wr_en after reset",  int'(wr_en), 0);
      chk(rd_idx == '0,   "R11", "rd_idx after reset", int'(rd_idx), 0);
   endtask

   task automatic t_write_basic;
      bit ok; int d; int c0;
      c0 = wr_cnt;
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      blk_write(8'd2, 8'd3, 3, ok, d);
      chk(ok, "R1", "0xD2 header acknowledged", int'(ok), 1);
      chk(d == 3, "R2", "data bytes acked", d, 3);
      chk(wr_cnt - c0 == 3, "R2", "write strobes", wr_cnt - c0, 3);
      chk(bank[2] == 8'h11 && bank[3] == 8'h22 && bank[4] == 8'h33, "R2",
          "regs 2..4", int'({bank[2], bank[3], bank[4]}), 'h112233);
   endtask

   task automatic t_read_basic;
      bit ok; logic [7:0] cnt;
      blk_read(8'd2, 3, ok, cnt);
      chk(ok, "R1", "0xD3 read header acknowledged", int'(ok), 1);
      chk(cnt == 8'h00, "R4", "count after reset", int'(cnt), 0);
      chk(rbuf[0] == 8'h11 && rbuf[1] == 8'h22 && rbuf[2] == 8'h33, "R4",
          "streamed regs 2..4", int'({rbuf[0], rbuf[1], rbuf[2]}), 'h112233);
   endtask

   task automatic t_count_reg;
      bit ok; int d; logic [7:0] cnt;
      wbuf[0] = 8'h03;
      blk_write(8'd8, 8'd1, 1, ok, d);
      blk_read(8'd2, 3, ok, cnt);
      chk(cnt == 8'h03, "R7", "count from register 8", int'(cnt), 3);
   endtask

   task automatic t_nack_release;
      bit a; logic [7:0] cnt; logic [7:0] b;
      bus_start;
      send_byte(8'hD2, a);
      send_byte(8'd3, a);
      bus_start;
      send_byte(8'hD3, a);
      recv_byte(1'b1, cnt);
      recv_byte(1'b0, b);
      chk(b == 8'h22, "R5", "byte before NACK", int'(b), 'h22);
      recv_byte(1'b0, b);
      chk(b == 8'hFF, "R5", "SDA released after NACK", int'(b), 'hFF);
      bus_stop;
   endtask

   task automatic t_wrong_addr;
      bit a; int c0;
      c0 = wr_cnt;
      bus_start;
      send_byte(8'hA4, a);
      chk(!a, "R1", "foreign address acked", int'(a), 0);
      send_byte(8'h00, a);
      send_byte(8'h01, a);
      send_byte(8'h55, a);
      chk(!a, "R1", "later byte acked after miss", int'(a), 0);
      bus_stop;
      chk(wr_cnt == c0, "R1", "writes after miss", wr_cnt - c0, 0);
   endtask

   task automatic t_overflow;
      bit ok; int d; int c0;
      c0 = wr_cnt;
      wbuf[0] = 8'h5A; wbuf[1] = 8'h6B;
      blk_write(8'd5, 8'd1, 2, ok, d);
      chk(d == 1, "R3", "acks with surplus byte", d, 1);
      chk(wr_cnt - c0 == 1, "R3", "strobes with surplus byte", wr_cnt - c0, 1);
      chk(bank[5] == 8'h5A && bank[6] == 8'hA6, "R3", "regs 5,6",
          int'({bank[5], bank[6]}), 'h5AA6);
   endtask

   task automatic t_readonly_wrap;
      bit ok; int d; int c0;
      c0 = wr_cnt;
      wbuf[0] = 8'hEE; wbuf[1] = 8'h77;
      blk_write(8'd15, 8'd2, 2, ok, d);
      chk(d == 2, "R8", "acks on protected index", d, 2);
      chk(wr_cnt - c0 == 1, "R8", "strobes on protected index", wr_cnt - c0, 1);
      chk(bank[15] == 8'hAF, "R8", "protected reg 15", int'(bank[15]), 'hAF);
      chk(bank[0] == 8'h77, "R6", "write wrapped to reg 0", int'(bank[0]), 'h77);
   endtask

   task automatic t_read_wrap;
      bit ok; logic [7:0] cnt;
      blk_read(8'd14, 3, ok, cnt);
      chk(rbuf[0] == 8'hAE && rbuf[1] == 8'hAF && rbuf[2] == 8'h77, "R6",
          "read wrap 14,15,0", int'({rbuf[0], rbuf[1], rbuf[2]}), 'hAEAF77);
   endtask

   task automatic t_abort;
      bit a; int c0; logic [7:0] cnt; int d; bit ok;
      c0 = wr_cnt;
      bus_start;
      send_byte(8'hD2, a);
      send_byte(8'd7, a);
      send_byte(8'd3, a);
      send_byte(8'h71, a);
      bus_start;
      send_byte(8'hD3, a);
      chk(a, "R9", "address rematched after restart", int'(a), 1);
      recv_byte(1'b0, cnt);
      bus_stop;
      chk(cnt == 8'h03, "R9", "count after aborted write", int'(cnt), 3);
      chk(bank[7] == 8'h71 && wr_cnt - c0 == 1, "R9", "acked byte kept",
          int'(bank[7]), 'h71);
      c0 = wr_cnt;
      bus_start;
      send_byte(8'hD2, a);
      send_byte(8'd1, a);
      send_byte(8'd2, a);
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      bus_stop;
      chk(wr_cnt == c0 && bank[1] == 8'hA1, "R9", "partial byte dropped on stop",
          int'(bank[1]), 'hA1);
      wbuf[0] = 8'h3C;
      blk_write(8'd1, 8'd1, 1, ok, d);
      chk(bank[1] == 8'h3C, "R9", "transfer after stop abort", int'(bank[1]), 'h3C);
   endtask

   task automatic finish_run;
      chk(oe_bad == 0, "R10", "sda_oe changes with SCL high", oe_bad, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      rst_n = 1'b0; scl = 1'b1; sda_h = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_write_basic;
      t_read_basic;
      t_count_reg;
      t_nack_release;
      t_wrong_addr;
      t_overflow;
      t_readonly_wrap;
      t_read_wrap;
      t_abort;
      done = 1'b1;
      finish_run;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule